// File: doc/BRIEF.md
# Flash Program/Erase Latch Controller

This block connects a simple request/acknowledge bus to a small on-chip flash array, which is modelled here as a register array of bytes. In normal operation the array can only be read, either as bytes or as 16-bit words. Writes that the bus sends to the array have no effect.

A three-bit control register selects how the array is altered. Software sets the latch bit. The next valid array write then loads a program address, data and size into holding latches. Setting the pulse bit starts a program or erase pulse of a fixed number of clock cycles, but only while the programming supply input is high. When the pulse ends, its result is committed to the array. Between pulses, software checks the result by reading the array over the same bus.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: A request is accepted on the rising edge where `req` is high. `ack` rises one cycle later for a byte access, for a word access at an even address, and for any control access. A word access at an odd address takes one extra cycle: `ack` is low after the first edge and rises after the second.
- R2: Array read data is formed as follows. A byte read returns `{8'h00, byte[a]}`. A word read returns `{byte[a], byte[a+1]}`, and `a+1` wraps inside the array.
- R3: After reset every array byte reads 8'hFF and the control register reads 0.
- R4: An array write while the latch bit is clear leaves the array unchanged.
- R5: While the latch bit is set and the latches are not yet loaded, the first array write that is a byte write, or a word write at an even address, loads address, data and size, and sets the loaded flag. An odd-address word write loads nothing. Array writes made after loading are ignored.
- R6: A program pulse ANDs the latched data into the array, and so can only clear bits. A byte program touches only `byte[a]`, using data bits 7:0. A word program sets `byte[a] &= d[15:8]` and `byte[a+1] &= d[7:0]`.
- R7: An erase pulse sets every array byte to 8'hFF. It does not need loaded latches.
- R8: A control write with the pulse bit set starts a pulse only when all of these hold: `vpp_ok` is high, no pulse is running, and either the erase bit in that same write is 1 or (the latches are loaded and the same write keeps the latch bit at 1). Otherwise the pulse bit is ignored.
- R9: A pulse lasts `PULSE_CYC` cycles. While it runs, each array byte reads as 8'hFF. The result is visible to the first read accepted after the pulse ends.
- R10: A control write with the latch bit at 0 clears the loaded flag. The block then returns to read-only behaviour.
- R11: The control register layout is: bit0 latch, bit1 erase select, bit2 pulse in progress (read-only), bit3 latches loaded (read-only). All other bits are 0. Control writes update bit0 and bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held for one cycle |
| wr | input | 1 | 1 write, 0 read |
| ctl_sel | input | 1 | 1 selects the control register, 0 selects the array |
| byte_sz | input | 1 | 1 byte access, 0 word access |
| addr | input | ADDR_W | Array byte address |
| wdata | input | 16 | Write data; a byte write uses bits 7:0 |
| vpp_ok | input | 1 | Programming supply present |
| ack | output | 1 | Access complete; `rdata` is valid in the same cycle |
| rdata | output | 16 | Read data |

## Verification
Each access result is due a fixed number of cycles after its request. A byte access, an even-address word access or a control access is due one cycle after the request. An odd-address word access is due two cycles after. The bench counts the cycles to `ack` and checks the count. A pulse started by a control write at edge k is shown as in progress to reads accepted at edges k+1 through k+PULSE_CYC, and its result is visible to the read accepted at edge k+PULSE_CYC+1. The bench issues back-to-back reads and checks each one against this schedule. All stimulus is driven, and all outputs sampled, on falling edges.

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl #(
  parameter int ADDR_W    = 6,
  parameter int PULSE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic              ctl_sel,
  input  logic              byte_sz,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              vpp_ok,
  output logic              ack,
  output logic [15:0]       rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PULSE_CYC + 1);

  logic [7:0]        mem [DEPTH];
  logic              lat, ers, loaded, pulse_on, pulse_ers, pl_byte, phase2;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] pl_addr, lo_addr;
  logic [15:0]       pl_data;

  wire odd_word = !byte_sz && addr[0];
  wire misal    = req && !ctl_sel && odd_word;
  wire arr_wr   = req && wr && !ctl_sel && !phase2;
  wire ctl_wr   = req && wr && ctl_sel && !phase2;
  wire capture  = arr_wr && lat && !loaded && !odd_word;
  wire start    = ctl_wr && wdata[2] && !pulse_on && vpp_ok &&
                  (wdata[1] || (loaded && wdata[0]));
  wire commit   = pulse_on && (cnt == '0);
  wire [7:0] ctl_rd = {4'b0, loaded, pulse_on, ers, lat};

  function automatic logic [7:0] rd(input logic [ADDR_W-1:0] a);
    return pulse_on ? 8'hFF : mem[a];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; phase2 <= 1'b0; rdata <= '0; lo_addr <= '0;
    end else if (phase2) begin
      ack <= 1'b1; phase2 <= 1'b0;
      rdata[7:0] <= rd(lo_addr);
    end else if (req) begin
      if (misal) begin
        ack <= 1'b0; phase2 <= 1'b1;
        lo_addr <= addr + 1'b1;
        rdata[15:8] <= rd(addr);
      end else begin
        ack <= 1'b1;
        if (ctl_sel)      rdata <= {8'h00, ctl_rd};
        else if (byte_sz) rdata <= {8'h00, rd(addr)};
        else              rdata <= {rd(addr), rd({addr[ADDR_W-1:1], 1'b1})};
      end
    end else begin
      ack <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat <= 1'b0; ers <= 1'b0; loaded <= 1'b0;
      pulse_on <= 1'b0; pulse_ers <= 1'b0; cnt <= '0;
      pl_addr <= '0; pl_data <= '0; pl_byte <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (ctl_wr) begin
        lat <= wdata[0];
        ers <= wdata[1];
        if (!wdata[0]) loaded <= 1'b0;
      end
      if (capture) begin
        loaded  <= 1'b1;
        pl_addr <= addr;
        pl_data <= wdata;
        pl_byte <= byte_sz;
      end
      if (start) begin
        pulse_on  <= 1'b1;
        pulse_ers <= wdata[1];
        cnt       <= CNT_W'(PULSE_CYC - 1);
      end else if (commit) begin
        pulse_on <= 1'b0;
        if (pulse_ers) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (pl_byte) begin
          mem[pl_addr] <= mem[pl_addr] & pl_data[7:0];
        end else begin
          mem[pl_addr] <= mem[pl_addr] & pl_data[15:8];
          mem[{pl_addr[ADDR_W-1:1], 1'b1}] <= mem[{pl_addr[ADDR_W-1:1], 1'b1}] & pl_data[7:0];
        end
      end else if (pulse_on) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  a_r1_aligned_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !phase2 && !misal) |=> ack);
  a_r1_misaligned_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !phase2 && misal) |=> (!ack && phase2));
  a_r1_second_phase: assert property (@(posedge clk) disable iff (!rst_n)
    phase2 |=> ack);
  a_r8_pulse_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_on) |-> $past(vpp_ok));
  a_r10_loaded_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> lat);
  a_r5_latches_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(loaded) && loaded) |-> ($stable(pl_addr) && $stable(pl_data)));

  for (genvar g = 0; g < DEPTH; g++) begin : g_chk
    a_r6_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(commit && pulse_ers) |-> ((mem[g] & ~$past(mem[g])) == 8'h00));
  end
endmodule

// File: tb/test_flash_pgm_ctrl.sv
module test_flash_pgm_ctrl;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int PC = 5;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, wr = 1'b0, ctl_sel = 1'b0, byte_sz = 1'b0, vpp_ok = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack;
  logic [15:0] rdata;
  int checks = 0, failures = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  flash_pgm_ctrl #(.ADDR_W(AW), .PULSE_CYC(PC)) i_flash_pgm_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .ctl_sel(ctl_sel), .byte_sz(byte_sz),
    .addr(addr), .wdata(wdata), .vpp_ok(vpp_ok), .ack(ack), .rdata(rdata));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic c, input logic w, input logic b, input int a,
                     input logic [15:0] d, output logic [15:0] r, output int cyc);
    req = 1'b1; ctl_sel = c; wr = w; byte_sz = b; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    cyc = 1;
    while (!ack && cyc < 8) begin @(negedge clk); cyc++; end
    r = rdata;
  endtask

  task automatic ctl_write(input logic [15:0] d);
    logic [15:0] r; int c;
    acc(1'b1, 1'b1, 1'b0, 0, d, r, c);
  endtask

  task automatic ctl_read(output logic [15:0] r);
    int c;
    acc(1'b1, 1'b0, 1'b0, 0, 16'h0, r, c);
  endtask

  task automatic sweep(input string tag);
    logic [15:0] r; int c;
    for (int a = 0; a < DEPTH; a++) begin
      acc(1'b0, 1'b0, 1'b1, a, 16'h0, r, c);
      check({tag, " byte R2"}, {16'(c), r}, {16'd1, 8'h00, model[a]});
      acc(1'b0, 1'b0, 1'b0, a, 16'h0, r, c);
      check({tag, " word R1 R2"}, {16'(c), r},
            {16'((a % 2) + 1), model[a], model[(a + 1) % DEPTH]});
    end
  endtask

  task automatic run_pulse(input logic [15:0] cmd, input logic is_erase);
    logic [15:0] r; int c;
    ctl_write(cmd);
    acc(1'b0, 1'b0, 1'b0, 0, 16'h0, r, c);
    check("R9 busy read", r, 16'hFFFF);
    for (int j = 2; j <= PC; j++) begin
      ctl_read(r);
      check("R9 pulse running", r[2], 1'b1);
    end
    ctl_read(r);
    check("R9 pulse ended", r[2], 1'b0);
    if (is_erase) for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
  endtask

  task automatic program_word(input int a, input logic [15:0] d);
    logic [15:0] r; int c;
    ctl_write(16'h0001);
    acc(1'b0, 1'b1, 1'b0, a, d, r, c);
    ctl_read(r);
    check("R5 loaded R11", r, 16'h0009);
    acc(1'b0, 1'b1, 1'b0, a, ~d, r, c);
    run_pulse(16'h0005, 1'b0);
    model[a] &= d[15:8];
    model[a + 1] &= d[7:0];
    ctl_write(16'h0000);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin @(negedge clk); wd++; end
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] r; int c;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ctl_read(r);
    check("R3 R11 control reset", r, 16'h0000);
    sweep("R3 reset array");

    acc(1'b0, 1'b1, 1'b1, 3, 16'h0000, r, c);
    acc(1'b0, 1'b1, 1'b0, 4, 16'h0000, r, c);
    sweep("R4 write ignored");

    vpp_ok = 1'b1;
    for (int a = 0; a < DEPTH; a += 2) program_word(a, 16'((a * 16'h2F1B) ^ 16'hA5C3));
    sweep("R6 first program");
    for (int a = 0; a < DEPTH; a += 2) program_word(a, 16'((a * 16'h1357) ^ 16'h7E99));
    sweep("R6 AND program");

    ctl_write(16'h0001);
    acc(1'b0, 1'b1, 1'b1, 7, 16'hFF00, r, c);
    run_pulse(16'h0005, 1'b0);
    model[7] &= 8'h00;
    ctl_write(16'h0000);
    sweep("R6 byte program");

    ctl_write(16'h0001);
    acc(1'b0, 1'b1, 1'b0, 9, 16'h0000, r, c);
    ctl_read(r);
    check("R5 odd word not latched", r, 16'h0001);
    ctl_write(16'h0005);
    ctl_read(r);
    check("R8 program needs loaded", r, 16'h0001);

    acc(1'b0, 1'b1, 1'b1, 9, 16'h0000, r, c);
    vpp_ok = 1'b0;
    ctl_write(16'h0005);
    ctl_read(r);
    check("R8 no supply", r, 16'h0009);
    repeat (PC + 2) @(negedge clk);
    sweep("R8 array untouched");

    ctl_write(16'h0000);
    ctl_read(r);
    check("R10 loaded cleared", r, 16'h0000);
    acc(1'b0, 1'b1, 1'b0, 10, 16'h0000, r, c);
    sweep("R10 read only");

    vpp_ok = 1'b1;
    run_pulse(16'h0006, 1'b1);
    ctl_read(r);
    check("R7 R11 erase control", r, 16'h0002);
    sweep("R7 erased");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule